// File: doc/BRIEF.md
# Shared CRC Engine with Raw and Post-Processed Results

This block computes a cyclic redundancy check over a stream of data beats. It is meant to be the single CRC resource that several channels of a transfer controller share. A seed write starts a calculation. It loads the CRC state and captures the polynomial, the CRC width (8, 16 or 32 bits), a final XOR mask and a reversal enable, all in one cycle. After that, each accepted beat of 1, 2 or 4 bytes advances the state by that many bits in one clock. The beat's bits go in most-significant first.

Two read-only views are always driven. The raw view is the CRC state, right-aligned, with no post-processing. This is the value a controller would store to its destination. The post-processed view applies the XOR mask to the raw value. It can then mirror all 32 bits, which moves a short CRC into the upper byte(s) of the word.

There is only one state and configuration set, so an owner lock protects it. The requester that writes the seed becomes the owner. Beats or seeds from any other requester are refused with a one-cycle error pulse. The lock is freed when the owner reads the post-processed result or releases it.

Top module: `crc_share_engine`

## Requirements
- R1: On reset the raw view, the post-processed view, `busy`, `owner` and `err` are all zero.
- R2: An allowed seed write loads the state with `seed_val` truncated to the selected width. It also captures the polynomial, the width code (0 = 8 bits, 1 = 16 bits, 2 = 32 bits), the XOR mask and the reversal enable. The raw view shows the seed from the cycle after the write. A seed from the owner during a calculation restarts it.
- R3: An accepted beat shifts in 8, 16 or 32 bits, selected by `beat_size` (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). The bits are taken from the right-aligned `beat_data`, most significant first. The step is a non-reflected CRC with the captured polynomial, and one beat is taken per cycle. The result is visible on the next cycle.
- R4: `raw_state` carries the CRC state with no post-processing, right-aligned. All bits above the selected width are zero.
- R5: `post_result` equals the raw value XORed with the captured 32-bit mask whenever reversal is off.
- R6: With reversal on, `post_result` is the XORed value mirrored over all 32 bits. An 8-bit CRC therefore sits in byte 3 and a 16-bit CRC in bytes 2 and 3.
- R7: `beat_ready` is low in any cycle that carries a seed write, and high otherwise. The seed takes priority.
- R8: A seed write when idle, or from the owner, sets `busy` and latches `seed_id` into `owner`. The lock clears in the cycle after the owner either reads (`res_rd` with `res_rd_id` = owner) or releases (`rel_req` with `rel_id` = owner).
- R9: A seed from a non-owner while busy, or a presented beat from a non-owner or while idle, gives `err` high for exactly the next cycle. State, configuration and owner stay unchanged.
- R10: A read or release carrying a non-owner ID leaves `busy` and `owner` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seed_wr | input | 1 | Seed and configuration write strobe |
| seed_id | input | ID_W | Requester issuing the seed |
| seed_val | input | 32 | Seed value, right-aligned |
| cfg_poly | input | 32 | Polynomial, right-aligned, implicit top bit omitted |
| cfg_len | input | 2 | CRC width code |
| cfg_xor | input | 32 | Final XOR mask |
| cfg_rev | input | 1 | Reverse the full result word |
| beat_valid | input | 1 | Beat present |
| beat_ready | output | 1 | Beat can be taken this cycle |
| beat_id | input | ID_W | Requester of the beat |
| beat_size | input | 2 | Beat size code |
| beat_data | input | 32 | Beat data, right-aligned |
| res_rd | input | 1 | Post-processed result read strobe |
| res_rd_id | input | ID_W | Requester doing the read |
| rel_req | input | 1 | Explicit lock release |
| rel_id | input | ID_W | Requester releasing |
| raw_state | output | 32 | Unprocessed CRC state |
| post_result | output | 32 | XORed and optionally mirrored result |
| busy | output | 1 | Lock held |
| owner | output | ID_W | Current lock holder |
| err | output | 1 | One-cycle refusal pulse |

## Verification
Every registered result shows up one cycle after the clock edge that accepts its stimulus. This covers the raw state, the post-processed view, `busy`, `owner` and the error pulse. Only `beat_ready` follows the seed strobe within the same cycle.

The bench drives its inputs just after a falling edge. A behavioural model updates on each rising edge, and the outputs are compared against it on every following falling edge, so each check lands on the first cycle its result is due. Directed checks use published check values (123456789) for an 8-bit, a 16-bit and a 32-bit CRC. They also cover the mirrored placement in the upper bytes, refusals of foreign requesters and the ordering of seed against beat.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
   // width code: 0 -> 8, 1 -> 16, other -> 32
   function automatic int crc_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 8;
         2'd1:    return 16;
         default: return 32;
      endcase
   endfunction

   // beat size code: 0 -> 1 byte, 1 -> 2 bytes, other -> 4 bytes
   function automatic int beat_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 8;
         2'd1:    return 16;
         default: return 32;
      endcase
   endfunction
endpackage

// File: rtl/crc_shift_net.sv
module crc_shift_net
   import crc_eng_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] poly_l,
   input  logic [W-1:0] data,
   input  logic [1:0]   size,
   output logic [W-1:0] nxt
);
   localparam int NSTAGE = W;

   logic [W-1:0] dl;
   int           nbits;
   logic [W-1:0] chain [NSTAGE+1];

   always_comb begin
      nbits = beat_bits(size);
      dl    = data << (W - nbits);
   end

   assign chain[0] = cur;

   for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
      logic         fb;
      logic [W-1:0] stepped;
      assign fb      = chain[k][W-1] ^ dl[W-1-k];
      assign stepped = {chain[k][W-2:0], 1'b0} ^ (fb ? poly_l : '0);
      assign chain[k+1] = (k < nbits) ? stepped : chain[k];
   end

   assign nxt = chain[NSTAGE];
endmodule

// File: rtl/crc_post_proc.sv
module crc_post_proc
   import crc_eng_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] st,
   input  logic [1:0]   len,
   input  logic [W-1:0] xorv,
   input  logic         rev,
   output logic [W-1:0] raw,
   output logic [W-1:0] post
);
   logic [W-1:0] xo;
   logic [W-1:0] mirrored;

   assign raw = st >> (W - crc_bits(len));
   assign xo  = raw ^ xorv;

   for (genvar i = 0; i < W; i++) begin : g_mirror
      assign mirrored[i] = xo[W-1-i];
   end

   assign post = rev ? mirrored : xo;
endmodule

// File: rtl/crc_owner_lock.sv
module crc_owner_lock #(
   parameter int ID_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            seed_wr,
   input  logic [ID_W-1:0] seed_id,
   input  logic            beat_valid,
   input  logic [ID_W-1:0] beat_id,
   input  logic            res_rd,
   input  logic [ID_W-1:0] res_rd_id,
   input  logic            rel_req,
   input  logic [ID_W-1:0] rel_id,
   output logic            seed_ok,
   output logic            beat_ok,
   output logic            busy,
   output logic [ID_W-1:0] owner,
   output logic            err
);
   logic seed_bad, beat_bad, unlock;

   always_comb begin
      seed_ok  = seed_wr && (!busy || seed_id == owner);
      seed_bad = seed_wr && !seed_ok;
      beat_ok  = beat_valid && !seed_wr && busy && beat_id == owner;
      beat_bad = beat_valid && !seed_wr && !beat_ok;
      unlock   = busy && ((res_rd && res_rd_id == owner) ||
                          (rel_req && rel_id == owner));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         owner <= '0;
         err   <= 1'b0;
      end else begin
         err <= seed_bad | beat_bad;
         if (seed_ok) begin
            busy  <= 1'b1;
            owner <= seed_id;
         end else if (unlock) begin
            busy <= 1'b0;
         end
      end
   end

   // R8
   lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(res_rd || rel_req));
   // R10
   owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !seed_wr) |=> $stable(owner));
   // R9
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(seed_wr || beat_valid));
endmodule

// File: rtl/crc_share_engine.sv
module crc_share_engine
   import crc_eng_pkg::*;
#(
   parameter int W    = 32,
   parameter int ID_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            seed_wr,
   input  logic [ID_W-1:0] seed_id,
   input  logic [W-1:0]    seed_val,
   input  logic [W-1:0]    cfg_poly,
   input  logic [1:0]      cfg_len,
   input  logic [W-1:0]    cfg_xor,
   input  logic            cfg_rev,
   input  logic            beat_valid,
   output logic            beat_ready,
   input  logic [ID_W-1:0] beat_id,
   input  logic [1:0]      beat_size,
   input  logic [W-1:0]    beat_data,
   input  logic            res_rd,
   input  logic [ID_W-1:0] res_rd_id,
   input  logic            rel_req,
   input  logic [ID_W-1:0] rel_id,
   output logic [W-1:0]    raw_state,
   output logic [W-1:0]    post_result,
   output logic            busy,
   output logic [ID_W-1:0] owner,
   output logic            err
);
   if (W != 32) begin : g_bad_w
      $error("crc_share_engine: W must be 32");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("crc_share_engine: ID_W must be at least 1");
   end

   logic [W-1:0] st_q, poly_q, xor_q, st_nxt;
   logic [1:0]   len_q;
   logic         rev_q;
   logic         seed_ok, beat_ok;

   assign beat_ready = !seed_wr;

   crc_owner_lock #(.ID_W(ID_W)) u_lock (
      .clk(clk), .rst_n(rst_n),
      .seed_wr(seed_wr), .seed_id(seed_id),
      .beat_valid(beat_valid), .beat_id(beat_id),
      .res_rd(res_rd), .res_rd_id(res_rd_id),
      .rel_req(rel_req), .rel_id(rel_id),
      .seed_ok(seed_ok), .beat_ok(beat_ok),
      .busy(busy), .owner(owner), .err(err)
   );

   crc_shift_net #(.W(W)) u_net (
      .cur(st_q), .poly_l(poly_q), .data(beat_data),
      .size(beat_size), .nxt(st_nxt)
   );

   crc_post_proc #(.W(W)) u_post (
      .st(st_q), .len(len_q), .xorv(xor_q), .rev(rev_q),
      .raw(raw_state), .post(post_result)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= '0;
         poly_q <= '0;
         xor_q  <= '0;
         len_q  <= '0;
         rev_q  <= 1'b0;
      end else if (seed_ok) begin
         st_q   <= seed_val << (W - crc_bits(cfg_len));
         poly_q <= cfg_poly << (W - crc_bits(cfg_len));
         xor_q  <= cfg_xor;
         len_q  <= cfg_len;
         rev_q  <= cfg_rev;
      end else if (beat_ok) begin
         st_q <= st_nxt;
      end
   end

   // R9
   state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!seed_wr && !(beat_valid && busy && beat_id == owner)) |=> $stable(raw_state));
   // R4
   raw_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len_q == 2'd0) |-> (raw_state[W-1:8] == '0));
endmodule

// File: tb/sim_crc_share_engine.sv
module sim_crc_share_engine;
   localparam int PER  = 10;
   localparam int ID_W = 2;

   logic clk = 0, rst_n = 0;
   logic seed_wr = 0, cfg_rev = 0, beat_valid = 0, res_rd = 0, rel_req = 0;
   logic [ID_W-1:0] seed_id = 0, beat_id = 0, res_rd_id = 0, rel_id = 0;
   logic [31:0] seed_val = 0, cfg_poly = 0, cfg_xor = 0, beat_data = 0;
   logic [1:0]  cfg_len = 0, beat_size = 0;
   logic        beat_ready, busy, err;
   logic [31:0] raw_state, post_result;
   logic [ID_W-1:0] owner;

   int n_run = 0, n_fail = 0;

   always #(PER/2) clk = ~clk;

   crc_share_engine #(.W(32), .ID_W(ID_W)) u0 (.*);

   // behavioural reference
   logic [31:0] m_st = 0, m_poly = 0, m_xor = 0;
   int          m_len = 8;
   logic        m_rev = 0, m_busy = 0, m_err = 0;
   logic [ID_W-1:0] m_owner = 0;

   function automatic int code_bits(input logic [1:0] c);
      return (c == 0) ? 8 : (c == 1) ? 16 : 32;
   endfunction

   function automatic logic [31:0] m_post();
      logic [31:0] x, r;
      x = m_st ^ m_xor;
      if (!m_rev) return x;
      for (int i = 0; i < 32; i++) r[i] = x[31-i];
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st <= 0; m_poly <= 0; m_xor <= 0; m_len <= 8; m_rev <= 0;
         m_busy <= 0; m_owner <= 0; m_err <= 0;
      end else begin
         logic ok_seed, ok_beat, bad;
         logic [31:0] s, mask;
         int nb;
         ok_seed = seed_wr && (!m_busy || seed_id == m_owner);
         ok_beat = beat_valid && !seed_wr && m_busy && beat_id == m_owner;
         bad = (seed_wr && !ok_seed) || (beat_valid && !seed_wr && !ok_beat);
         m_err <= bad;
         if (ok_seed) begin
            int L;
            L = code_bits(cfg_len);
            mask = (L == 32) ? 32'hFFFF_FFFF : ((32'd1 << L) - 1);
            m_st <= seed_val & mask; m_poly <= cfg_poly & mask;
            m_xor <= cfg_xor; m_len <= L; m_rev <= cfg_rev;
            m_busy <= 1; m_owner <= seed_id;
         end else begin
            if (ok_beat) begin
               mask = (m_len == 32) ? 32'hFFFF_FFFF : ((32'd1 << m_len) - 1);
               s = m_st;
               nb = code_bits(beat_size);
               for (int b = nb - 1; b >= 0; b--) begin
                  logic fb;
                  fb = s[m_len-1] ^ beat_data[b];
                  s = (s << 1) & mask;
                  if (fb) s = s ^ m_poly;
               end
               m_st <= s;
            end
            if (m_busy && ((res_rd && res_rd_id == m_owner) ||
                           (rel_req && rel_id == m_owner)))
               m_busy <= 0;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // per-clock comparison against the reference
   always @(negedge clk) if (rst_n) begin
      chk("R4 raw", raw_state, m_st);
      chk("R5/R6 post", post_result, m_post());
      chk("R8 busy", {31'd0, busy}, {31'd0, m_busy});
      chk("R8 owner", {30'd0, owner}, {30'd0, m_owner});
      chk("R9 err", {31'd0, err}, {31'd0, m_err});
      chk("R7 ready", {31'd0, beat_ready}, {31'd0, !seed_wr});
   end

   task automatic clr();
      seed_wr = 0; beat_valid = 0; res_rd = 0; rel_req = 0;
   endtask

   task automatic quiet();
      @(negedge clk); #1; clr();
   endtask

   task automatic seed(input int id, input logic [31:0] v, input logic [31:0] p,
                       input logic [1:0] l, input logic [31:0] x, input logic r);
      @(negedge clk); #1; clr();
      seed_wr = 1; seed_id = id[ID_W-1:0]; seed_val = v; cfg_poly = p;
      cfg_len = l; cfg_xor = x; cfg_rev = r;
   endtask

   task automatic beat(input int id, input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk); #1; clr();
      beat_valid = 1; beat_id = id[ID_W-1:0]; beat_size = sz; beat_data = d;
   endtask

   task automatic rd(input int id);
      @(negedge clk); #1; clr(); res_rd = 1; res_rd_id = id[ID_W-1:0];
   endtask

   task automatic rel(input int id);
      @(negedge clk); #1; clr(); rel_req = 1; rel_id = id[ID_W-1:0];
   endtask

   task automatic bytes9(input int id);
      beat(id, 0, 32'h31); beat(id, 0, 32'h32); beat(id, 0, 32'h33);
      beat(id, 0, 32'h34); beat(id, 0, 32'h35); beat(id, 0, 32'h36);
      beat(id, 0, 32'h37); beat(id, 0, 32'h38); beat(id, 0, 32'h39);
   endtask

   initial begin
      #(PER * 200000);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] held;
      #(PER * 3 + 2);
      // R1 reset state
      chk("R1 raw", raw_state, 0);
      chk("R1 post", post_result, 0);
      chk("R1 busy", {31'd0, busy}, 0);
      chk("R1 err", {31'd0, err}, 0);
      rst_n = 1;

      // R3 8-bit CRC, byte beats
      seed(1, 0, 32'h07, 0, 0, 0);
      quiet();
      chk("R2 seed loaded", raw_state, 0);
      chk("R8 owner latched", {30'd0, owner}, 1);
      bytes9(1);
      quiet();
      chk("R3 crc8 check", raw_state, 32'hF4);
      chk("R5 post no rev", post_result, 32'hF4);
      chk("R4 upper zero", {8'd0, raw_state[31:8]}, 0);

      // R9 foreign beat and seed
      held = raw_state;
      beat(2, 0, 32'hAA);
      quiet();
      chk("R9 err on foreign beat", {31'd0, err}, 1);
      chk("R9 state kept", raw_state, held);
      seed(2, 32'h55, 32'h07, 0, 0, 0);
      quiet();
      chk("R9 err on foreign seed", {31'd0, err}, 1);
      chk("R9 owner kept", {30'd0, owner}, 1);
      chk("R9 state kept after seed", raw_state, held);
      quiet();
      chk("R9 err one cycle", {31'd0, err}, 0);

      // R10 non-owner read / release
      rd(2); rel(3);
      quiet();
      chk("R10 still busy", {31'd0, busy}, 1);
      rd(1);
      quiet();
      chk("R8 unlocked by read", {31'd0, busy}, 0);

      // R9 beat while idle
      beat(1, 0, 32'h11);
      quiet();
      chk("R9 err idle beat", {31'd0, err}, 1);

      // R6 8-bit reversed
      seed(3, 0, 32'h07, 0, 0, 1);
      bytes9(3);
      quiet();
      chk("R6 crc8 byte3", post_result, 32'h2F00_0000);

      // R2 owner reseed mid-calc, masked to width
      seed(3, 32'h1234_ABCD, 32'h1021, 1, 0, 0);
      quiet();
      chk("R2 reseed masked", raw_state, 32'h0000_ABCD);
      rel(3);
      quiet();
      chk("R8 unlocked by release", {31'd0, busy}, 0);

      // R3 16-bit CRC, halfword beats, reversed
      seed(0, 32'hFFFF, 32'h1021, 1, 0, 1);
      beat(0, 1, 32'h3132); beat(0, 1, 32'h3334);
      beat(0, 1, 32'h3536); beat(0, 1, 32'h3738); beat(0, 0, 32'h39);
      quiet();
      chk("R3 crc16 check", raw_state, 32'h29B1);
      chk("R6 crc16 bytes2-3", post_result, 32'h8D94_0000);
      rel(0);

      // R7 seed beats a concurrent beat
      @(negedge clk); #1; clr();
      seed_wr = 1; seed_id = 2; seed_val = 32'hFFFF_FFFF; cfg_poly = 32'h04C1_1DB7;
      cfg_len = 2; cfg_xor = 32'hFFFF_FFFF; cfg_rev = 0;
      beat_valid = 1; beat_id = 2; beat_size = 2; beat_data = 32'hDEAD_BEEF;
      #1;
      chk("R7 ready low on seed", {31'd0, beat_ready}, 0);
      quiet();
      chk("R7 beat not taken", raw_state, 32'hFFFF_FFFF);
      chk("R9 no err for held beat", {31'd0, err}, 0);

      // R3 32-bit CRC, word beats
      beat(2, 2, 32'h3132_3334); beat(2, 2, 32'h3536_3738); beat(2, 0, 32'h39);
      quiet();
      chk("R4 crc32 raw", raw_state, 32'h0376_E6E7);
      chk("R5 crc32 post", post_result, 32'hFC89_1918);
      rd(2);
      quiet();
      chk("R8 unlocked", {31'd0, busy}, 0);

      repeat (3) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule